// File: doc/BRIEF.md
# System Configuration Register Block

This block is a 4 KB window of 32-bit registers on a simple single-cycle bus (valid, write, byte address, write data, read data). It holds two general-purpose configuration words, the low byte of the second one driving eight LED pins. It also holds three read-only identification words set by parameters, and a clock-lock status word.

The block's main feature is an indirect configuration channel to a small bank of oscillator-frequency registers. Software first places an outbound value in the data-out register. It then writes a control word that names a function and a device, chooses read or write, and sets a start bit. The access completes in the same clock edge that captures the control write. A done flag and an error flag appear in the status register, and for reads the oscillator value appears in the data-return register. Only function 1 with a device number below the bank size is accepted.

The lock status word has a software-writable mask in its top byte. Its bit 0 reports whether any masked lock-status bit is set. All lock-status bits are tied high.

Top module: `sys_cfg_regs`

## Requirements
- R1: After reset, CTRL (0x0A8) reads 0x0010_0000, DLL (0x100) reads 0xFFFF_0001, and CFG0, CFG1, DATA_RTN, DATA_OUT and STAT read 0. The oscillators 0, 1 and 2 hold 50,000,000, 24,576,000 and 25,000,000.
- R2: CFG0 (0x000), CFG1 (0x004) and DATA_OUT (0x0A4) store the full 32-bit written value, and led_out always equals CFG1[7:0].
- R3: A write to CTRL stores the value with bit 31 (start), bits 29:26 and bits 19:12 forced to 0. The other bits (device 11:0, function 25:20, write 30) read back as written.
- R4: Every CTRL write clears STAT (0x0AC). A CTRL write with start=0 leaves STAT at 0 and touches no oscillator and no DATA_RTN.
- R5: A CTRL write with start=1, write=1, function=1 and device<3 copies DATA_OUT into the chosen oscillator and sets STAT to 1 (done=bit 0).
- R6: A CTRL write with start=1, write=0, function=1 and device<3 loads the chosen oscillator into DATA_RTN (0x0A0) and sets STAT to 1.
- R7: A started transaction with function≠1 or device≥3 sets STAT to 3 (error=bit 1 with done). It changes no oscillator and leaves DATA_RTN as it was.
- R8: A DLL write changes only bits 31:24 (lock mask). Bits 23:16 read 0xFF and bits 15:1 read 0, and bit 0 reads the OR of the mask ANDed with bits 23:16.
- R9: CFG3 (0x00C) and unmapped offsets read 0. CFG4 (0x010), AID (0xFF8) and ID (0xFFC) read their parameter values, and writes to any of these leave all registers unchanged.
- R10: The results of a transaction are readable by the first read issued on the cycle after the CTRL write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when no read |
| led_out | output | 8 | LED drive from CFG1[7:0] |

## Verification
The checker assumes that bus_write and bus_addr are meaningful only while bus_valid is high, and that each access lasts one cycle with a word-aligned offset. It also assumes rst_n is held low for at least one edge before traffic starts. The bench drives each access for exactly one clock period, starting and ending at falling edges, and always uses aligned offsets. It samples the combinational read data in the middle of the low phase.

// File: rtl/sys_cfg_regs.sv
module sys_cfg_regs #(
  parameter int unsigned NUM_OSC = 3,
  parameter logic [31:0] OSC_RST [NUM_OSC] = '{32'd50000000, 32'd24576000, 32'd25000000},
  parameter logic [31:0] CFG4_VAL = 32'h0,
  parameter logic [31:0] AID_VAL  = 32'h0,
  parameter logic [31:0] ID_VAL   = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic [7:0]  led_out
);
  localparam logic [11:0] A_CFG0 = 12'h000, A_CFG1 = 12'h004, A_CFG3 = 12'h00C,
                          A_CFG4 = 12'h010, A_RTN  = 12'h0A0, A_DOUT = 12'h0A4,
                          A_CTRL = 12'h0A8, A_STAT = 12'h0AC, A_DLL  = 12'h100,
                          A_AID  = 12'hFF8, A_ID   = 12'hFFC;
  localparam logic [31:0] CTRL_KEEP = 32'h43F0_0FFF;
  localparam logic [7:0]  LOCKED = 8'hFF;

  logic [31:0] cfg0_q, cfg1_q, rtn_q, dout_q, ctrl_q;
  logic [1:0]  stat_q;
  logic [7:0]  dll_mask_q;
  logic [31:0] osc_q [NUM_OSC];
  logic [31:0] osc_sel;

  wire        wr      = bus_valid && bus_write;
  wire        ctrl_wr = wr && bus_addr == A_CTRL;
  wire        start   = bus_wdata[31];
  wire [11:0] dev     = bus_wdata[11:0];
  wire        hit     = bus_wdata[25:20] == 6'd1 && 32'(dev) < NUM_OSC;
  wire        go      = ctrl_wr && start && hit;

  always_comb begin
    osc_sel = '0;
    for (int i = 0; i < NUM_OSC; i++)
      if (32'(dev) == i) osc_sel = osc_q[i];
  end

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    always_ff @(posedge clk)
      if (!rst_n) osc_q[g] <= OSC_RST[g];
      else if (go && bus_wdata[30] && 32'(dev) == g) osc_q[g] <= dout_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg0_q     <= '0;
      cfg1_q     <= '0;
      rtn_q      <= '0;
      dout_q     <= '0;
      ctrl_q     <= 32'h0010_0000;
      stat_q     <= '0;
      dll_mask_q <= 8'hFF;
    end else if (wr) begin
      case (bus_addr)
        A_CFG0: cfg0_q <= bus_wdata;
        A_CFG1: cfg1_q <= bus_wdata;
        A_DOUT: dout_q <= bus_wdata;
        A_DLL:  dll_mask_q <= bus_wdata[31:24];
        A_CTRL: begin
          ctrl_q <= bus_wdata & CTRL_KEEP;
          stat_q <= start ? {~hit, 1'b1} : 2'b00;
          if (go && !bus_wdata[30]) rtn_q <= osc_sel;
        end
        default: ;
      endcase
    end
  end

  wire [31:0] dll_word = {dll_mask_q, LOCKED, 15'h0, |(dll_mask_q & LOCKED)};

  always_comb begin
    bus_rdata = '0;
    if (bus_valid && !bus_write)
      case (bus_addr)
        A_CFG0: bus_rdata = cfg0_q;
        A_CFG1: bus_rdata = cfg1_q;
        A_CFG3: bus_rdata = '0;
        A_CFG4: bus_rdata = CFG4_VAL;
        A_RTN:  bus_rdata = rtn_q;
        A_DOUT: bus_rdata = dout_q;
        A_CTRL: bus_rdata = ctrl_q;
        A_STAT: bus_rdata = {30'h0, stat_q};
        A_DLL:  bus_rdata = dll_word;
        A_AID:  bus_rdata = AID_VAL;
        A_ID:   bus_rdata = ID_VAL;
        default: bus_rdata = '0;
      endcase
  end

  assign led_out = cfg1_q[7:0];
endmodule

module sys_cfg_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_valid,
  input logic        bus_write,
  input logic [11:0] bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [7:0]  led_out,
  input logic [1:0]  stat,
  input logic [7:0]  mask
);
  wire ctrl_w = bus_valid && bus_write && bus_addr == 12'h0A8;

  // R2
  led_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_write && bus_addr == 12'h004 |=> led_out == $past(bus_wdata[7:0]));
  // R4
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && !bus_wdata[31] |=> stat == 2'b00);
  // R5
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_w && bus_wdata[31] |=> stat[0]);
  // R7
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat[1] |-> stat[0]);
  // R8
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && bus_addr == 12'h100) |=> $stable(mask));
  // R9
  cfg3_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && bus_addr == 12'h00C |-> bus_rdata == 32'h0);
  // R3
  ctrl_start_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && bus_addr == 12'h0A8 |-> !bus_rdata[31]);
endmodule

bind sys_cfg_regs sys_cfg_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .led_out(led_out), .stat(stat_q), .mask(dll_mask_q)
);

// File: tb/sim_sys_cfg_regs.sv
module sim_sys_cfg_regs;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_valid = 0, bus_write = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  led_out;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  sys_cfg_regs #(.AID_VAL(32'h0A1D_0002), .ID_VAL(32'h5A5A_0001)) u0 (
    .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_wdata, .bus_rdata, .led_out);

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
    bus_valid = 0;
  endtask

  task automatic t_reset;
    rd_chk("R1", 12'h0A8, 32'h0010_0000);
    rd_chk("R1", 12'h100, 32'hFFFF_0001);
    rd_chk("R1", 12'h000, 0);
    rd_chk("R1", 12'h004, 0);
    rd_chk("R1", 12'h0A0, 0);
    rd_chk("R1", 12'h0A4, 0);
    rd_chk("R1", 12'h0AC, 0);
    check("R1", {24'h0, led_out}, 0);
    foreach (OSCX[i]) begin
      wr(12'h0A8, 32'h8010_0000 | i);
      rd_chk("R1", 12'h0A0, OSCX[i]);
    end
  endtask

  logic [31:0] OSCX [3] = '{32'd50000000, 32'd24576000, 32'd25000000};

  task automatic t_regs;
    wr(12'h000, 32'hA5A5_0F0F);
    wr(12'h004, 32'h1234_56C3);
    wr(12'h0A4, 32'hCAFE_F00D);
    rd_chk("R2", 12'h000, 32'hA5A5_0F0F);
    rd_chk("R2", 12'h004, 32'h1234_56C3);
    rd_chk("R2", 12'h0A4, 32'hCAFE_F00D);
    check("R2", {24'h0, led_out}, 32'hC3);
  endtask

  task automatic t_ctrl;
    wr(12'h0A8, 32'hFFFF_FFFF);
    rd_chk("R3", 12'h0A8, 32'h43F0_0FFF);
    rd_chk("R7", 12'h0AC, 3);
    wr(12'h0A8, 32'h0010_0001);
    rd_chk("R4", 12'h0AC, 0);
    rd_chk("R4", 12'h0A0, OSCX[2]);
  endtask

  task automatic t_osc;
    wr(12'h0A4, 32'h0000_1234);
    wr(12'h0A8, 32'hC010_0002);
    rd_chk("R5 R10", 12'h0AC, 1);
    wr(12'h0A8, 32'h8010_0002);
    rd_chk("R6 R10", 12'h0A0, 32'h0000_1234);
    rd_chk("R6", 12'h0AC, 1);
    wr(12'h0A8, 32'h8010_0001);
    rd_chk("R6", 12'h0A0, OSCX[1]);
    wr(12'h0A8, 32'h8010_0002);
  endtask

  task automatic t_bad;
    wr(12'h0A4, 32'h0000_DEAD);
    wr(12'h0A8, 32'hC010_0003);
    rd_chk("R7", 12'h0AC, 3);
    wr(12'h0A8, 32'h8010_0003);
    rd_chk("R7", 12'h0AC, 3);
    rd_chk("R7", 12'h0A0, 32'h0000_1234);
    wr(12'h0A8, 32'hC020_0000);
    rd_chk("R7", 12'h0AC, 3);
    wr(12'h0A8, 32'h8000_0000);
    rd_chk("R7", 12'h0A0, 32'h0000_1234);
    wr(12'h0A8, 32'h8010_0000);
    rd_chk("R7", 12'h0A0, OSCX[0]);
  endtask

  task automatic t_dll;
    wr(12'h100, 32'h00FF_FFFE);
    rd_chk("R8", 12'h100, 32'h00FF_0000);
    wr(12'h100, 32'h1000_0000);
    rd_chk("R8", 12'h100, 32'h10FF_0001);
  endtask

  task automatic t_ro;
    rd_chk("R9", 12'h010, 0);
    rd_chk("R9", 12'hFF8, 32'h0A1D_0002);
    rd_chk("R9", 12'hFFC, 32'h5A5A_0001);
    wr(12'h00C, 32'hFFFF_FFFF);
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'hFF8, 32'hFFFF_FFFF);
    wr(12'hFFC, 32'hFFFF_FFFF);
    wr(12'h0AC, 32'hFFFF_FFFF);
    wr(12'h0A0, 32'hFFFF_FFFF);
    wr(12'h200, 32'hFFFF_FFFF);
    rd_chk("R9", 12'h00C, 0);
    rd_chk("R9", 12'h010, 0);
    rd_chk("R9", 12'hFF8, 32'h0A1D_0002);
    rd_chk("R9", 12'hFFC, 32'h5A5A_0001);
    rd_chk("R9", 12'h0AC, 1);
    rd_chk("R9", 12'h0A0, OSCX[0]);
    rd_chk("R9", 12'h200, 0);
    rd_chk("R9", 12'h000, 32'hA5A5_0F0F);
    rd_chk("R9", 12'h004, 32'h1234_56C3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_regs();
    t_ctrl();
    t_osc();
    t_bad();
    t_dll();
    t_ro();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule